// File: doc/BRIEF.md
# Triangular spread-spectrum offset generator

This block produces the frequency-offset profile that a fractional-N feedback divider needs to spread a pixel clock. The profile is a triangle: a straight ramp one way, a straight ramp back, repeated once per modulation period. The profile is counted in reference-clock cycles. Software-facing logic presents three settings together with a one-cycle load strobe: the modulation rate in hertz, the depth in units of 1/10000 of nominal, and a spread kind code. It also presents the nominal output frequency in kHz. The block checks these settings against their legal ranges. It keeps each new set pending until the waveform reaches its starting point, and then streams a signed offset every reference cycle.

Two spread kinds are offered. Centre spread swings the offset equally above and below nominal. Down spread keeps the offset at or below zero, so the clock never runs faster than nominal. A separate flag warns when the worst-case peak output frequency would pass a 165 MHz ceiling. For centre spread, that worst case allows 20 % extra on top of the depth. An illegal set raises an error flag and parks the modulation at zero.

Top module: `ssc_tri_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, ssc_off is 0, ssc_run is 0, cfg_err is 0 and over_lim is 0. ssc_vld is 0 during reset.
- R2: A depth (cfg_depth, units of 1/10000 of nominal) is legal only when it lies from 10 to 310 inclusive and is a multiple of 10.
- R3: cfg_kind code 1 selects centre spread and code 3 selects down spread. Codes 0 and 2 make the set illegal.
- R4: A rate cfg_fmod_hz is legal only when 32000 <= cfg_fmod_hz and cfg_fmod_hz * 200 <= REF_HZ.
- R5: One cycle after a load strobe carrying an illegal set, cfg_err reads 1. The period in progress then ends normally. From the next period boundary, ssc_run is 0 and ssc_off is 0 even with en high, and this holds until a legal set is loaded.
- R6: Let N = floor(REF_HZ / cfg_fmod_hz). The leg length L is floor(N/4) for centre spread and floor(N/2) for down spread, and a period is 4L cycles (centre) or 2L cycles (down). The amplitude A is depth * 2^(SUB_BITS-1) for centre and depth * 2^SUB_BITS for down. The step is s = floor(A / L). ssc_off is two's complement in units of 2^-SUB_BITS / 10000 of nominal.
- R7: With k counted in cycles from the period start, a centre-spread period outputs k*s for k <= L, then (2L-k)*s for k <= 3L, then (k-4L)*s. The output starts and ends at 0.
- R8: A down-spread period outputs -k*s for k <= L, then -(2L-k)*s. The output is never positive.
- R9: over_lim is updated one cycle after each load strobe. It reads 1 when nom*(100000 + 12*depth) > 165000*100000 for centre spread, or when nom > 165000 for down spread, with nom in kHz. It reads 0 for an illegal set.
- R10: A loaded set takes effect only at a period boundary, where ssc_off is 0. A period already running finishes with the old set. When modulation is idle, the first cycle after the load is a boundary.
- R11: en is looked at only at period boundaries. Once en is low, the running period completes, and ssc_off then stays 0 with ssc_run 0. When idle, raising en starts a period on the next edge, with ssc_off at 0.
- R12: ssc_vld is 1 on every cycle after reset. ssc_off never moves by more than one step of the active set between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | One-cycle strobe that captures the configuration inputs |
| en | input | 1 | Modulation enable, sampled at period boundaries |
| cfg_fmod_hz | input | 20 | Modulation rate in Hz |
| cfg_depth | input | 9 | Depth in units of 1/10000 of nominal |
| cfg_kind | input | 2 | Spread kind code: 1 centre, 3 down |
| cfg_nom_khz | input | 18 | Nominal output frequency in kHz, used for the ceiling check |
| ssc_off | output | 24 | Signed frequency offset, fraction of nominal |
| ssc_vld | output | 1 | Offset valid strobe, high every cycle after reset |
| ssc_run | output | 1 | High while a modulation period is in progress |
| cfg_err | output | 1 | Last loaded set was illegal |
| over_lim | output | 1 | Last loaded set can push the peak above the ceiling |

## Verification
On every cycle, the bound checker enforces the following properties. The down-spread offset never rises above zero. The centre offset stays inside its amplitude. The offset sits at zero whenever modulation is idle. No cycle moves the offset by more than one step. The active set changes only on a boundary cycle. Other behaviours can only be shown by the bench's scenarios. These are the exact ramp values and period lengths for each rate, depth and kind, and the legality decisions at each range edge. They also include the ceiling flag on both sides of 165 MHz, and the finishing of the running period before a new set, a dropped enable or an illegal set takes hold.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
  localparam int FMOD_W  = 20;
  localparam int DEPTH_W = 9;
  localparam int KIND_W  = 2;
  localparam int NOM_W   = 18;
  localparam int LEG_W   = 16;
  localparam int AMP_W   = 24;

  localparam logic [KIND_W-1:0] KIND_CENTER = 2'd1;
  localparam logic [KIND_W-1:0] KIND_DOWN   = 2'd3;

  typedef struct packed {
    logic             valid;
    logic             center;
    logic [LEG_W-1:0] leg;
    logic [AMP_W-1:0] step;
    logic [AMP_W-1:0] amp;
  } ssc_cfg_t;

  function automatic logic depth_legal(input logic [DEPTH_W-1:0] d, input int unsigned lo,
                                       input int unsigned hi, input int unsigned inc);
    int unsigned v;
    v = 32'(d);
    return (v >= lo) && (v <= hi) && ((v % inc) == 0);
  endfunction

  function automatic logic rate_legal(input logic [FMOD_W-1:0] f, input longint unsigned ref_hz,
                                      input longint unsigned fmin, input longint unsigned div);
    longint unsigned v;
    v = 64'(f);
    return (v >= fmin) && (v * div <= ref_hz);
  endfunction

  function automatic logic [LEG_W-1:0] leg_cycles(input logic [FMOD_W-1:0] f,
                                                  input longint unsigned ref_hz, input logic center);
    longint unsigned n;
    if (f == '0) return '0;
    n = ref_hz / 64'(f);
    return center ? LEG_W'(n / 64'd4) : LEG_W'(n / 64'd2);
  endfunction

  function automatic logic [AMP_W-1:0] peak_amp(input logic [DEPTH_W-1:0] d, input logic center,
                                                input int unsigned sub);
    logic [AMP_W-1:0] a;
    a = AMP_W'(d);
    return center ? (a << (sub - 1)) : (a << sub);
  endfunction

  function automatic logic [AMP_W-1:0] step_size(input logic [AMP_W-1:0] amp,
                                                 input logic [LEG_W-1:0] leg);
    if (leg == '0) return '0;
    return amp / AMP_W'(leg);
  endfunction

  function automatic logic peak_over(input logic [NOM_W-1:0] nom, input logic [DEPTH_W-1:0] d,
                                     input logic center, input longint unsigned ceil_khz);
    longint unsigned scale;
    scale = center ? (64'd100000 + 64'd12 * 64'(d)) : 64'd100000;
    return (64'(nom) * scale) > (ceil_khz * 64'd100000);
  endfunction
endpackage

// File: rtl/ssc_cfg_check.sv
`timescale 1ns/1ps
module ssc_cfg_check
  import ssc_pkg::*;
#(
  parameter longint unsigned REF_HZ    = 64'd25_600_000,
  parameter int unsigned     SUB_BITS  = 12,
  parameter longint unsigned FMOD_MIN  = 64'd32_000,
  parameter longint unsigned RATE_DIV  = 64'd200,
  parameter int unsigned     DEPTH_MIN = 10,
  parameter int unsigned     DEPTH_MAX = 310,
  parameter int unsigned     DEPTH_INC = 10,
  parameter longint unsigned CEIL_KHZ  = 64'd165_000
) (
  input  logic [FMOD_W-1:0]  fmod_hz,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [KIND_W-1:0]  kind,
  input  logic [NOM_W-1:0]   nom_khz,
  output ssc_cfg_t           cfg,
  output logic               over
);
  logic kind_ok, center, legal;
  logic [LEG_W-1:0] leg;
  logic [AMP_W-1:0] amp;

  assign center  = (kind == KIND_CENTER);
  assign kind_ok = center || (kind == KIND_DOWN);
  assign legal   = kind_ok && depth_legal(depth, DEPTH_MIN, DEPTH_MAX, DEPTH_INC)
                           && rate_legal(fmod_hz, REF_HZ, FMOD_MIN, RATE_DIV);
  assign leg     = leg_cycles(fmod_hz, REF_HZ, center);
  assign amp     = peak_amp(depth, center, SUB_BITS);

  always_comb begin
    cfg.valid  = legal;
    cfg.center = center;
    cfg.leg    = leg;
    cfg.amp    = amp;
    cfg.step   = step_size(amp, leg);
  end

  assign over = legal && peak_over(nom_khz, depth, center, CEIL_KHZ);
endmodule

// File: rtl/ssc_ramp.sv
`timescale 1ns/1ps
module ssc_ramp
  import ssc_pkg::*;
#(
  parameter int OFF_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    nxt_valid,
  input  logic                    center,
  input  logic [LEG_W-1:0]        leg_len,
  input  logic [AMP_W-1:0]        step,
  output logic                    bnd,
  output logic                    run,
  output logic signed [OFF_W-1:0] off
);
  logic [1:0]              idx;
  logic [LEG_W-1:0]        cnt;
  logic                    leg_end, last_leg, rise;
  logic signed [OFF_W-1:0] delta;

  assign leg_end  = (cnt == leg_len - LEG_W'(1));
  assign last_leg = center ? (idx == 2'd3) : (idx == 2'd1);
  assign rise     = center ? ((idx == 2'd0) || (idx == 2'd3)) : (idx == 2'd1);
  assign bnd      = !run || (leg_end && last_leg);
  assign delta    = $signed(OFF_W'(step));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      idx <= '0;
      cnt <= '0;
      off <= '0;
    end else if (bnd) begin
      run <= en && nxt_valid;
      idx <= '0;
      cnt <= '0;
      off <= '0;
    end else begin
      off <= rise ? (off + delta) : (off - delta);
      if (leg_end) begin
        cnt <= '0;
        idx <= idx + 2'd1;
      end else begin
        cnt <= cnt + LEG_W'(1);
      end
    end
  end
endmodule

// File: rtl/ssc_tri_gen.sv
`timescale 1ns/1ps
module ssc_tri_gen
  import ssc_pkg::*;
#(
  parameter longint unsigned REF_HZ   = 64'd25_600_000,
  parameter int unsigned     SUB_BITS = 12,
  parameter int              OFF_W    = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld,
  input  logic                    en,
  input  logic [FMOD_W-1:0]       cfg_fmod_hz,
  input  logic [DEPTH_W-1:0]      cfg_depth,
  input  logic [KIND_W-1:0]       cfg_kind,
  input  logic [NOM_W-1:0]        cfg_nom_khz,
  output logic signed [OFF_W-1:0] ssc_off,
  output logic                    ssc_vld,
  output logic                    ssc_run,
  output logic                    cfg_err,
  output logic                    over_lim
);
  ssc_cfg_t chk_cfg, pcfg, acfg, nxt_cfg;
  logic     chk_over, pend, bnd, vld_q, err_q, over_q;

  ssc_cfg_check #(.REF_HZ(REF_HZ), .SUB_BITS(SUB_BITS)) u_check (
    .fmod_hz(cfg_fmod_hz), .depth(cfg_depth), .kind(cfg_kind), .nom_khz(cfg_nom_khz),
    .cfg(chk_cfg), .over(chk_over)
  );

  assign nxt_cfg = pend ? pcfg : acfg;

  ssc_ramp #(.OFF_W(OFF_W)) u_ramp (
    .clk(clk), .rst(rst), .en(en), .nxt_valid(nxt_cfg.valid),
    .center(acfg.center), .leg_len(acfg.leg), .step(acfg.step),
    .bnd(bnd), .run(ssc_run), .off(ssc_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcfg   <= '0;
      acfg   <= '0;
      pend   <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      over_q <= 1'b0;
    end else begin
      vld_q <= 1'b1;
      if (bnd) acfg <= nxt_cfg;
      if (ld) begin
        pcfg   <= chk_cfg;
        pend   <= 1'b1;
        err_q  <= !chk_cfg.valid;
        over_q <= chk_over;
      end else if (bnd) begin
        pend <= 1'b0;
      end
    end
  end

  assign ssc_vld  = vld_q;
  assign cfg_err  = err_q;
  assign over_lim = over_q;
endmodule

// File: rtl/ssc_tri_gen_chk.sv
`timescale 1ns/1ps
module ssc_tri_gen_chk
  import ssc_pkg::*;
#(
  parameter int OFF_W = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    run,
  input logic                    bnd,
  input logic                    center,
  input logic [AMP_W-1:0]        step,
  input logic [AMP_W-1:0]        amp,
  input logic signed [OFF_W-1:0] off,
  input ssc_cfg_t                acfg
);
  AST_DOWN_NEVER_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (run && !center) |-> (off <= 0)); // R8

  AST_CENTER_WITHIN_AMP: assert property (@(posedge clk) disable iff (rst)
    (run && center) |-> ((off <= $signed({1'b0, amp})) && (off >= -$signed({1'b0, amp})))); // R7

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (off == '0)); // R7

  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |-> (off == '0)); // R11

  AST_SLEW_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    ((off - $past(off)) <= $signed({1'b0, $past(step)})) &&
    (($past(off) - off) <= $signed({1'b0, $past(step)}))); // R12

  AST_CFG_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$past(bnd) |-> $stable(acfg)); // R10
endmodule

bind ssc_tri_gen ssc_tri_gen_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .run(ssc_run), .bnd(bnd), .center(acfg.center),
  .step(acfg.step), .amp(acfg.amp), .off(ssc_off), .acfg(acfg)
);

// File: tb/ssc_tri_gen_tb.sv
`timescale 1ns/1ps
module ssc_tri_gen_tb;
  localparam int REF = 25_600_000;

  typedef struct packed {
    int fm; int d; int t; int nom; bit err; bit over;
  } vec_t;

  // fm, depth, kind, nom_khz, expected err, expected over
  localparam vec_t VEC [15] = '{
    '{128000,  50, 3, 100000, 1'b0, 1'b0},  // R4 top rate, down
    '{100000,  10, 1, 164800, 1'b0, 1'b0},  // R9 centre just under
    '{100000,  10, 1, 164900, 1'b0, 1'b1},  // R9 centre just over
    '{ 32000, 310, 3, 165000, 1'b0, 1'b0},  // R9 down equal to ceiling
    '{ 32000, 310, 3, 165001, 1'b0, 1'b1},  // R9 down above ceiling
    '{ 50000, 250, 1, 150000, 1'b0, 1'b0},  // R7 deep centre
    '{128000,  15, 3, 100000, 1'b1, 1'b0},  // R2 not multiple of 10
    '{128000, 320, 3, 100000, 1'b1, 1'b0},  // R2 above max
    '{128000,   0, 3, 100000, 1'b1, 1'b0},  // R2 below min
    '{128000,  50, 2, 100000, 1'b1, 1'b0},  // R3 code 2
    '{128000,  50, 0, 100000, 1'b1, 1'b0},  // R3 code 0
    '{ 31999,  50, 3, 100000, 1'b1, 1'b0},  // R4 below min rate
    '{128001,  50, 3, 100000, 1'b1, 1'b0},  // R4 above ref/200
    '{128000, 310, 1, 100000, 1'b0, 1'b0},  // R6 shortest centre leg
    '{ 32000,  10, 1, 100000, 1'b0, 1'b0}   // R6 longest centre leg
  };

  logic clk = 1'b0, rst = 1'b1, ld = 1'b0, en = 1'b0;
  logic [19:0] fm = '0;
  logic [8:0]  dep = '0;
  logic [1:0]  kind = '0;
  logic [17:0] nom = '0;
  logic signed [23:0] off;
  logic vld, run, err, over;
  int n_chk = 0, n_err = 0, vld_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssc_tri_gen u_dut (
    .clk(clk), .rst(rst), .ld(ld), .en(en), .cfg_fmod_hz(fm), .cfg_depth(dep),
    .cfg_kind(kind), .cfg_nom_khz(nom), .ssc_off(off), .ssc_vld(vld), .ssc_run(run),
    .cfg_err(err), .over_lim(over)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int leg_of(input int f, input bit c);
    int n;
    n = REF / f;
    return c ? n / 4 : n / 2;
  endfunction

  function automatic int step_of(input int d, input bit c, input int l);
    return (c ? d * 2048 : d * 4096) / l;
  endfunction

  function automatic int exp_off(input bit c, input int l, input int s, input int k);
    int p, kk;
    p = c ? 4 * l : 2 * l;
    kk = k % p;
    if (c) begin
      if (kk <= l) return kk * s;
      if (kk <= 3 * l) return (2 * l - kk) * s;
      return (kk - 4 * l) * s;
    end
    if (kk <= l) return -kk * s;
    return -(2 * l - kk) * s;
  endfunction

  // compares samples k0..k1 (one per negedge), leaves at sample k1+1
  task automatic span(input bit c, input int l, input int s, input int k0, input int k1,
                      inout int mism);
    for (int k = k0; k <= k1; k++) begin
      if (off !== 24'(exp_off(c, l, s, k)) || run !== 1'b1) mism++;
      if (vld !== 1'b1) vld_bad++;
      @(negedge clk);
    end
  endtask

  task automatic load(input int f, input int d, input int t, input int nk);
    @(negedge clk);
    fm = 20'(f); dep = 9'(d); kind = 2'(t); nom = 18'(nk); ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic idle_span(input int n, inout int mism);
    for (int i = 0; i < n; i++) begin
      if (run !== 1'b0 || off !== 24'sd0) mism++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int mism, l, s, p, cnt, la, sa, lb, sb;
    bit c;
    vec_t v;
    repeat (3) @(negedge clk);
    check("R1 off in reset", off, 0);
    check("R1 run in reset", run, 0);
    check("R1 err/over in reset", {err, over}, 0);
    check("R1 vld low in reset", vld, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 vld after reset", vld, 1);
    check("R1 idle after reset", {run, err, over, (off != 0)}, 0);

    for (int i = 0; i < 15; i++) begin
      v = VEC[i];
      load(v.fm, v.d, v.t, v.nom);
      check("R2/R3/R4 err flag", err, v.err);
      check("R9 over flag", over, v.over);
      @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      if (!v.err) begin
        c = (v.t == 1);
        l = leg_of(v.fm, c);
        s = step_of(v.d, c, l);
        p = c ? 4 * l : 2 * l;
        mism = 0;
        span(c, l, s, 0, p, mism);
        check("R6/R7/R8 waveform", mism, 0);
        en = 1'b0;
        cnt = 0;
        while (run === 1'b1 && cnt < 4000) begin @(negedge clk); cnt++; end
        check("R11 stops at zero", {run, (off != 0)}, 0);
      end else begin
        mism = 0;
        idle_span(20, mism);
        check("R5 idle on illegal set", mism, 0);
        en = 1'b0;
      end
    end

    // R10: reload mid-period, applies at the boundary only
    la = leg_of(128000, 1'b0); sa = step_of(50, 1'b0, la);
    lb = leg_of(128000, 1'b1); sb = step_of(100, 1'b1, lb);
    load(128000, 50, 3, 100000);
    @(negedge clk); en = 1'b1; @(negedge clk);
    mism = 0;
    span(1'b0, la, sa, 0, 29, mism);
    fm = 20'd128000; dep = 9'd100; kind = 2'd1; nom = 18'd100000; ld = 1'b1;
    span(1'b0, la, sa, 30, 30, mism);
    ld = 1'b0;
    span(1'b0, la, sa, 31, 2 * la - 1, mism);
    span(1'b1, lb, sb, 0, 4 * lb, mism);
    check("R10 set applied at boundary", mism, 0);

    // R11: enable dropped mid-period
    en = 1'b0;
    mism = 0;
    span(1'b1, lb, sb, 4 * lb + 1, 8 * lb - 1, mism);
    idle_span(20, mism);
    check("R11 finish period then hold", mism, 0);

    // R5: illegal load during a running period
    load(128000, 50, 3, 100000);
    @(negedge clk); en = 1'b1; @(negedge clk);
    mism = 0;
    span(1'b0, la, sa, 0, 9, mism);
    dep = 9'd15; ld = 1'b1;
    span(1'b0, la, sa, 10, 10, mism);
    ld = 1'b0;
    check("R5 err after illegal load", err, 1);
    span(1'b0, la, sa, 11, 2 * la - 1, mism);
    idle_span(30, mism);
    check("R5 period completes then parks", mism, 0);
    check("R5 err holds", err, 1);
    en = 1'b0;

    check("R12 vld every cycle", vld_bad, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule